// File: doc/BRIEF.md
# Video Pixel Port Formatter

The formatter takes one stream of internal pixel data, either 10-bit luma and chroma for 4:2:2 video or 8-bit red, green and blue for 4:4:4 graphics, and lays it onto a 20-pin parallel output bus. A mode input selects one of these formats:
- single-stream 8-bit or 10-bit 4:2:2 with embedded line codes
- two-stream 16-bit or 20-bit 4:2:2
- double-rate 12-bit RGB
- double-rate 8-bit or 10-bit 4:2:2

For every pin, the block produces a rising-half value, a falling-half value and an output enable. A pad stage outside the block applies these to the pins. Horizontal sync, vertical sync and a field/data-enable strobe come out in step with the data, and each has its own polarity control.

In the single-stream modes, upstream holds each input sample for two clocks. The block sends the sample's chroma word first and its luma word second. It frames every active line with a start code and an end code.

The block loads a new mode only when a frame begins. A change on the mode input therefore never splits a frame.

Top module: `pix_port_fmt`

## Requirements
- R1: After reset and until the first frame start, every enable bit and every data bit is 0, whatever `mode_i` holds.
- R2: The block samples `mode_i` only on the clock where a rising `vs_i` reaches the output stage. That output word already uses the new mode. A change of `mode_i` at any other time has no effect.
- R3: In the single-stream modes the word order within a line is chroma, luma, chroma, luma. Mode 0 places word bits 9:2 on pins 19:12 with enable 0xFF000. Mode 1 places the full 10-bit word on pins 19:10 with enable 0xFFC00.
- R4: In the single-stream modes, the four clocks before the first active word carry the start code and the four clocks after the last active word carry the end code. Each code is 0x3FF, 0x000, 0x000 and then a status word. The status word is the byte {1,F,V,H,V^H,F^H,F^V,F^V^H} followed by two zero bits. F is the field input, V is the vertical-sync input, H is 0 for the start code and 1 for the end code.
- R5: Mode 2 places luma bits 9:2 on pins 19:12 and chroma bits 9:2 on pins 9:2, with enable 0xFF3FC. Mode 3 places luma on pins 19:10 and chroma on pins 9:0, with enable 0xFFFFF.
- R6: Mode 4 drives pins 19:8 with enable 0xFFF00. The rising half carries {blue[7:0], green[3:0]} and the falling half carries {red[7:0], green[7:4]}.
- R7: Modes 5 and 6 carry one pixel per clock. Chroma goes on the rising half and luma on the falling half. Mode 5 uses bits 9:2 on pins 19:12 with enable 0xFF000. Mode 6 uses all 10 bits on pins 19:10 with enable 0xFFC00.
- R8: The chroma sample is Cb for pixels at an even position counted from the start of the current line and Cr for pixels at an odd position. The count restarts at 0 on every line.
- R9: Data and the sync outputs have the same latency. Input sampled on clock edge n appears after edge n+5. The HS, VS and field/data-enable outputs are inverted when `pol_i` bit 0, 1 or 2 respectively is set.
- R10: The field/data-enable output carries the field input in modes 0 and 1 and the data-enable input in every other mode.
- R11: A pin whose enable bit is 0 is driven with 0. Mode 7 disables all pins.
- R12: Outside the active line and its codes, the block sends black: luma 0x040, chroma 0x200, RGB all zero. In the single-stream modes the chroma/luma word order continues to alternate through blanking.
- R13: In modes 0 to 3 the falling-half value equals the rising-half value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Requested format (0..7) |
| pol_i | input | 3 | Inversion for HS, VS, field/DE outputs |
| de_i | input | 1 | Active-video strobe |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync, rising edge starts a frame |
| field_i | input | 1 | Field indicator |
| y_i | input | 10 | Luma |
| cb_i | input | 10 | Blue-difference chroma |
| cr_i | input | 10 | Red-difference chroma |
| r_i | input | 8 | Red |
| g_i | input | 8 | Green |
| b_i | input | 8 | Blue |
| pd_rise_o | output | 20 | Pin values, rising half |
| pd_fall_o | output | 20 | Pin values, falling half |
| pd_oe_o | output | 20 | Per-pin output enable |
| hs_o | output | 1 | Aligned horizontal sync |
| vs_o | output | 1 | Aligned vertical sync |
| fde_o | output | 1 | Aligned field or data enable |

## Verification
The hardest situation to reach is chroma parity carried over from a previous line. The bench sends a line with an odd pixel count and then, with no frame start in between, a second line. The second line's first chroma sample must be Cb. A second hard case is a mode request that arrives in the middle of a frame. The bench changes `mode_i` between two lines of the same frame and checks that the pin map and enables stay unchanged until the next vertical-sync edge. Each line is captured cycle by cycle, so that the code words, the active words and the following blanking words can all be checked against their exact positions.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
  localparam int PIX_W    = 10;
  localparam int RGB_W    = 8;
  localparam int BUS_W    = 2 * PIX_W;
  localparam int CODE_LEN = 4;
  localparam int NARROW_W = PIX_W - 2;

  localparam logic [PIX_W-1:0] BLK_Y = PIX_W'(10'h040);
  localparam logic [PIX_W-1:0] BLK_C = PIX_W'(10'h200);

  typedef enum logic [2:0] {
    M_SDR8    = 3'd0,
    M_SDR10   = 3'd1,
    M_SDR16   = 3'd2,
    M_SDR20   = 3'd3,
    M_DDR_RGB = 3'd4,
    M_DDR8    = 3'd5,
    M_DDR10   = 3'd6,
    M_OFF     = 3'd7
  } mode_e;

  typedef struct packed {
    logic             de;
    logic             hs;
    logic             vs;
    logic             fld;
    logic [PIX_W-1:0] y;
    logic [PIX_W-1:0] cb;
    logic [PIX_W-1:0] cr;
    logic [RGB_W-1:0] r;
    logic [RGB_W-1:0] g;
    logic [RGB_W-1:0] b;
  } px_t;

  function automatic logic is_single_stream(mode_e m);
    return (m == M_SDR8) || (m == M_SDR10);
  endfunction
endpackage

// File: rtl/pixfmt_align.sv
module pixfmt_align
  import pixfmt_pkg::*;
#(
  parameter int DEPTH = CODE_LEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  px_t              px_i,
  output px_t              px_o,
  output logic [DEPTH-1:0] lead_o,
  output logic [DEPTH-1:0] trail_o
);
  px_t pipe [DEPTH+1];
  logic [DEPTH-1:0] trail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe[0] <= '0;
    else         pipe[0] <= px_i;
  end

  for (genvar i = 1; i <= DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe[i] <= '0;
      else         pipe[i] <= pipe[i-1];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_lead
    assign lead_o[i] = pipe[i].de;
  end

  // de history behind the output stage, used to time the end code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trail_q <= '0;
    else         trail_q <= {trail_q[DEPTH-2:0], pipe[DEPTH].de};
  end

  assign px_o    = pipe[DEPTH];
  assign trail_o = trail_q;
endmodule

// File: rtl/pixfmt_timecode.sv
module pixfmt_timecode
  import pixfmt_pkg::*;
(
  input  logic                cur_de_i,
  input  logic [CODE_LEN-1:0] lead_i,
  input  logic [CODE_LEN-1:0] trail_i,
  input  logic                fld_i,
  input  logic                vs_i,
  output logic                code_v_o,
  output logic [PIX_W-1:0]    code_w_o
);
  localparam int IW = $clog2(CODE_LEN);

  logic          sav, eav, h_bit;
  logic [IW-1:0] sav_idx, eav_idx, idx;
  logic [7:0]    status;

  assign sav     = ~cur_de_i & lead_i[0];
  assign eav     = ~cur_de_i & trail_i[CODE_LEN-1];
  assign sav_idx = IW'($countones(lead_i[CODE_LEN-1:1]));
  assign eav_idx = IW'(CODE_LEN - 1 - $countones(trail_i[CODE_LEN-2:0]));
  assign h_bit   = eav;
  assign idx     = eav ? eav_idx : sav_idx;

  assign status = {1'b1, fld_i, vs_i, h_bit,
                   vs_i ^ h_bit, fld_i ^ h_bit, fld_i ^ vs_i, fld_i ^ vs_i ^ h_bit};

  always_comb begin
    unique case (idx)
      IW'(0):          code_w_o = '1;
      IW'(CODE_LEN-1): code_w_o = {status, {(PIX_W-8){1'b0}}};
      default:         code_w_o = '0;
    endcase
  end

  assign code_v_o = sav | eav;
endmodule

// File: rtl/pixfmt_lane_map.sv
module pixfmt_lane_map
  import pixfmt_pkg::*;
(
  input  mode_e             mode_i,
  input  logic [PIX_W-1:0]  word_i,
  input  logic [PIX_W-1:0]  y_i,
  input  logic [PIX_W-1:0]  c_i,
  input  logic [RGB_W-1:0]  r_i,
  input  logic [RGB_W-1:0]  g_i,
  input  logic [RGB_W-1:0]  b_i,
  output logic [BUS_W-1:0]  rise_o,
  output logic [BUS_W-1:0]  fall_o,
  output logic [BUS_W-1:0]  oe_o
);
  localparam int HALF_G = RGB_W / 2;
  localparam int RGB_LN = RGB_W + HALF_G;

  always_comb begin
    rise_o = '0;
    fall_o = '0;
    oe_o   = '0;
    unique case (mode_i)
      M_SDR8: begin
        rise_o[BUS_W-1 -: NARROW_W] = word_i[PIX_W-1 -: NARROW_W];
        oe_o[BUS_W-1 -: NARROW_W]   = '1;
      end
      M_SDR10: begin
        rise_o[BUS_W-1 -: PIX_W] = word_i;
        oe_o[BUS_W-1 -: PIX_W]   = '1;
      end
      M_SDR16: begin
        rise_o[BUS_W-1 -: NARROW_W] = y_i[PIX_W-1 -: NARROW_W];
        rise_o[PIX_W-1 -: NARROW_W] = c_i[PIX_W-1 -: NARROW_W];
        oe_o[BUS_W-1 -: NARROW_W]   = '1;
        oe_o[PIX_W-1 -: NARROW_W]   = '1;
      end
      M_SDR20: begin
        rise_o = {y_i, c_i};
        oe_o   = '1;
      end
      M_DDR_RGB: begin
        rise_o[BUS_W-1 -: RGB_LN] = {b_i, g_i[HALF_G-1:0]};
        fall_o[BUS_W-1 -: RGB_LN] = {r_i, g_i[RGB_W-1:HALF_G]};
        oe_o[BUS_W-1 -: RGB_LN]   = '1;
      end
      M_DDR8: begin
        rise_o[BUS_W-1 -: NARROW_W] = c_i[PIX_W-1 -: NARROW_W];
        fall_o[BUS_W-1 -: NARROW_W] = y_i[PIX_W-1 -: NARROW_W];
        oe_o[BUS_W-1 -: NARROW_W]   = '1;
      end
      M_DDR10: begin
        rise_o[BUS_W-1 -: PIX_W] = c_i;
        fall_o[BUS_W-1 -: PIX_W] = y_i;
        oe_o[BUS_W-1 -: PIX_W]   = '1;
      end
      default: ;
    endcase
    if (mode_i inside {M_SDR8, M_SDR10, M_SDR16, M_SDR20}) fall_o = rise_o;
  end
endmodule

// File: rtl/pix_port_fmt.sv
module pix_port_fmt
  import pixfmt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic [2:0]       pol_i,
  input  logic             de_i,
  input  logic             hs_i,
  input  logic             vs_i,
  input  logic             field_i,
  input  logic [PIX_W-1:0] y_i,
  input  logic [PIX_W-1:0] cb_i,
  input  logic [PIX_W-1:0] cr_i,
  input  logic [RGB_W-1:0] r_i,
  input  logic [RGB_W-1:0] g_i,
  input  logic [RGB_W-1:0] b_i,
  output logic [BUS_W-1:0] pd_rise_o,
  output logic [BUS_W-1:0] pd_fall_o,
  output logic [BUS_W-1:0] pd_oe_o,
  output logic             hs_o,
  output logic             vs_o,
  output logic             fde_o
);
  px_t                 px_in, cur;
  logic [CODE_LEN-1:0] lead, trail;
  logic                code_v;
  logic [PIX_W-1:0]    code_w;

  assign px_in = '{de: de_i, hs: hs_i, vs: vs_i, fld: field_i,
                   y: y_i, cb: cb_i, cr: cr_i, r: r_i, g: g_i, b: b_i};

  pixfmt_align #(.DEPTH(CODE_LEN)) u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .px_i   (px_in),
    .px_o   (cur),
    .lead_o (lead),
    .trail_o(trail)
  );

  pixfmt_timecode u_code (
    .cur_de_i(cur.de),
    .lead_i  (lead),
    .trail_i (trail),
    .fld_i   (cur.fld),
    .vs_i    (cur.vs),
    .code_v_o(code_v),
    .code_w_o(code_w)
  );

  // mode is loaded only when a frame start reaches the output stage
  logic  vs_q, frame_start;
  mode_e mode_q, eff_mode;

  assign frame_start = cur.vs & ~vs_q;
  assign eff_mode    = frame_start ? mode_e'(mode_i) : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q   <= 1'b0;
      mode_q <= M_OFF;
    end else begin
      vs_q   <= cur.vs;
      mode_q <= eff_mode;
    end
  end

  // word phase (single-stream) and pixel parity, both restarted per line
  logic ph_q, odd_q, wph, wodd, a_start, single;

  assign a_start = cur.de & ~trail[0];
  assign single  = is_single_stream(eff_mode);
  assign wph     = a_start ? 1'b0 : ph_q;
  assign wodd    = a_start ? 1'b0 : odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 1'b0;
      odd_q <= 1'b0;
    end else begin
      ph_q  <= ~wph;
      odd_q <= single ? (wodd ^ wph) : ~wodd;
    end
  end

  logic [PIX_W-1:0] y_s, cb_s, cr_s, c_s, word;
  logic [RGB_W-1:0] r_s, g_s, b_s;

  assign y_s  = cur.de ? cur.y  : BLK_Y;
  assign cb_s = cur.de ? cur.cb : BLK_C;
  assign cr_s = cur.de ? cur.cr : BLK_C;
  assign r_s  = cur.de ? cur.r  : '0;
  assign g_s  = cur.de ? cur.g  : '0;
  assign b_s  = cur.de ? cur.b  : '0;
  assign c_s  = wodd ? cr_s : cb_s;
  assign word = code_v ? code_w : (wph ? y_s : c_s);

  logic [BUS_W-1:0] rise_d, fall_d, oe_d;

  pixfmt_lane_map u_map (
    .mode_i(eff_mode),
    .word_i(word),
    .y_i   (y_s),
    .c_i   (c_s),
    .r_i   (r_s),
    .g_i   (g_s),
    .b_i   (b_s),
    .rise_o(rise_d),
    .fall_o(fall_d),
    .oe_o  (oe_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_rise_o <= '0;
      pd_fall_o <= '0;
      pd_oe_o   <= '0;
      hs_o      <= 1'b0;
      vs_o      <= 1'b0;
      fde_o     <= 1'b0;
    end else begin
      pd_rise_o <= rise_d;
      pd_fall_o <= fall_d;
      pd_oe_o   <= oe_d;
      hs_o      <= cur.hs ^ pol_i[0];
      vs_o      <= cur.vs ^ pol_i[1];
      fde_o     <= (single ? cur.fld : cur.de) ^ pol_i[2];
    end
  end
endmodule

// File: rtl/pix_port_fmt_chk.sv
module pix_port_fmt_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hs_i,
  input logic [2:0]  pol_i,
  input logic [2:0]  mode_q,
  input logic        frame_start,
  input logic [19:0] pd_rise_o,
  input logic [19:0] pd_fall_o,
  input logic [19:0] pd_oe_o,
  input logic        hs_o
);
  logic [2:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 3'd7)   cyc_q <= cyc_q + 3'd1;
  end

  p_pad_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pd_rise_o & ~pd_oe_o) == '0) && ((pd_fall_o & ~pd_oe_o) == '0));

  p_oe_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> $stable(pd_oe_o));

  p_sdr_single_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q < 3'd4 && !frame_start) |=> (pd_fall_o == pd_rise_o));

  p_hs_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 3'd7) |-> (hs_o == ($past(hs_i, 6) ^ $past(pol_i[0]))));
endmodule

bind pix_port_fmt pix_port_fmt_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hs_i       (hs_i),
  .pol_i      (pol_i),
  .mode_q     (mode_q),
  .frame_start(frame_start),
  .pd_rise_o  (pd_rise_o),
  .pd_fall_o  (pd_fall_o),
  .pd_oe_o    (pd_oe_o),
  .hs_o       (hs_o)
);

// File: tb/sim_pix_port_fmt.sv
module sim_pix_port_fmt;
  localparam int CLK_PERIOD = 10;
  localparam int T = 40;
  localparam int NV = 11;

  // {mode_i, expected mode, field, pol, active clocks, frame start, spare, expected oe}
  localparam logic [35:0] VEC [NV] = '{
    {3'd3, 3'd3, 1'b0, 3'b000, 4'd8, 1'b1, 1'b0, 20'hFFFFF},
    {3'd3, 3'd3, 1'b0, 3'b000, 4'd3, 1'b0, 1'b0, 20'hFFFFF},
    {3'd3, 3'd3, 1'b0, 3'b000, 4'd4, 1'b0, 1'b0, 20'hFFFFF},
    {3'd0, 3'd3, 1'b0, 3'b000, 4'd8, 1'b0, 1'b0, 20'hFFFFF},
    {3'd0, 3'd0, 1'b0, 3'b000, 4'd8, 1'b1, 1'b0, 20'hFF000},
    {3'd1, 3'd1, 1'b1, 3'b111, 4'd8, 1'b1, 1'b0, 20'hFFC00},
    {3'd2, 3'd2, 1'b0, 3'b010, 4'd8, 1'b1, 1'b0, 20'hFF3FC},
    {3'd4, 3'd4, 1'b0, 3'b000, 4'd8, 1'b1, 1'b0, 20'hFFF00},
    {3'd5, 3'd5, 1'b0, 3'b001, 4'd8, 1'b1, 1'b0, 20'hFF000},
    {3'd6, 3'd6, 1'b0, 3'b000, 4'd8, 1'b1, 1'b0, 20'hFFC00},
    {3'd7, 3'd7, 1'b0, 3'b000, 4'd8, 1'b1, 1'b0, 20'h00000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] mode_i = 3'd3, pol_i = 3'b000;
  logic de_i = 0, hs_i = 0, vs_i = 0, field_i = 0;
  logic [9:0] y_i = '0, cb_i = '0, cr_i = '0;
  logic [7:0] r_i = '0, g_i = '0, b_i = '0;
  logic [19:0] pd_rise_o, pd_fall_o, pd_oe_o;
  logic hs_o, vs_o, fde_o;

  int checks = 0, failures = 0;
  logic [19:0] cap_r [T], cap_f [T], cap_oe [T];
  logic        cap_hs [T], cap_vs [T], cap_fde [T];

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_port_fmt u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .pol_i(pol_i),
    .de_i(de_i), .hs_i(hs_i), .vs_i(vs_i), .field_i(field_i),
    .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i), .r_i(r_i), .g_i(g_i), .b_i(b_i),
    .pd_rise_o(pd_rise_o), .pd_fall_o(pd_fall_o), .pd_oe_o(pd_oe_o),
    .hs_o(hs_o), .vs_o(vs_o), .fde_o(fde_o)
  );

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s got %h exp %h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] yv(input int k);  return 10'(32'h100 + k); endfunction
  function automatic logic [9:0] cbv(input int k); return 10'(32'h300 + k); endfunction
  function automatic logic [9:0] crv(input int k); return 10'(32'h180 + k); endfunction
  function automatic logic [7:0] rv(input int k);  return 8'(32'hA0 + k); endfunction
  function automatic logic [7:0] gv(input int k);  return 8'(32'h3C + k); endfunction
  function automatic logic [7:0] bv(input int k);  return 8'(32'hC1 + k); endfunction

  function automatic logic [19:0] map(input int m, input logic [9:0] c, input logic [9:0] y,
                                      input logic [7:0] r, input logic [7:0] g,
                                      input logic [7:0] b, input bit fall);
    case (m)
      0: return {c[9:2], 12'h0};
      1: return {c, 10'h0};
      2: return {y[9:2], 2'b0, c[9:2], 2'b0};
      3: return {y, c};
      4: return fall ? {r, g[7:4], 8'h0} : {b, g[3:0], 8'h0};
      5: return fall ? {y[9:2], 12'h0} : {c[9:2], 12'h0};
      6: return fall ? {y, 10'h0} : {c, 10'h0};
      default: return 20'h0;
    endcase
  endfunction

  function automatic logic [19:0] exp_active(input int m, input int j, input bit fall);
    int k;
    logic [9:0] w;
    if (m <= 1) begin
      k = j / 2;
      w = (j % 2 == 0) ? ((k % 2 == 0) ? cbv(k) : crv(k)) : yv(k);
      return map(m, w, 10'h0, 8'h0, 8'h0, 8'h0, fall);
    end
    return map(m, (j % 2 == 0) ? cbv(j) : crv(j), yv(j), rv(j), gv(j), bv(j), fall);
  endfunction

  function automatic logic [9:0] status_w(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  task automatic run_line(input logic [35:0] e);
    int m, em, a, k;
    bit fl, dovs;
    logic [2:0] pl;
    logic [19:0] eoe;
    string tg;
    logic [9:0] sav [4], eav [4];
    m = int'(e[35:33]); em = int'(e[32:30]); fl = e[29]; pl = e[28:26];
    a = int'(e[25:22]); dovs = e[21]; eoe = e[19:0];
    mode_i = 3'(m); pol_i = pl; field_i = fl;
    for (int c = 0; c < T; c++) begin
      @(negedge clk);
      cap_r[c] = pd_rise_o; cap_f[c] = pd_fall_o; cap_oe[c] = pd_oe_o;
      cap_hs[c] = hs_o; cap_vs[c] = vs_o; cap_fde[c] = fde_o;
      vs_i = dovs && (c < 2);
      hs_i = (c == 5);
      de_i = (c >= 10) && (c < 10 + a);
      k = (em <= 1) ? (c - 10) / 2 : c - 10;
      if (de_i) begin
        y_i = yv(k); cb_i = cbv(k); cr_i = crv(k); r_i = rv(k); g_i = gv(k); b_i = bv(k);
      end else begin
        y_i = 10'h3FF; cb_i = 10'h0; cr_i = 10'h3FF; r_i = 8'hFF; g_i = 8'hFF; b_i = 8'hFF;
      end
    end
    case (em)
      0, 1: tg = "R3";
      2, 3: tg = "R5";
      4: tg = "R6";
      5, 6: tg = "R7";
      default: tg = "R11";
    endcase
    chk((m != em) ? "R2 oe" : {tg, " oe"}, cap_oe[16], eoe);
    for (int j = 0; j < a; j++) begin
      chk({tg, " rise"}, cap_r[16 + j], exp_active(em, j, 1'b0));
      chk({tg, " fall"}, cap_f[16 + j], exp_active(em, j, 1'b1));
    end
    if (em <= 1) begin
      sav = '{10'h3FF, 10'h000, 10'h000, status_w(fl, 1'b0, 1'b0)};
      eav = '{10'h3FF, 10'h000, 10'h000, status_w(fl, 1'b0, 1'b1)};
      for (int i = 0; i < 4; i++) begin
        chk("R4 start code", cap_r[12 + i], map(em, sav[i], 10'h0, 8'h0, 8'h0, 8'h0, 1'b0));
        chk("R4 end code", cap_r[24 + i], map(em, eav[i], 10'h0, 8'h0, 8'h0, 8'h0, 1'b0));
      end
      chk("R12 blank chroma", cap_r[28], map(em, 10'h200, 10'h0, 8'h0, 8'h0, 8'h0, 1'b0));
      chk("R12 blank luma", cap_r[29], map(em, 10'h040, 10'h0, 8'h0, 8'h0, 8'h0, 1'b0));
      chk("R10 field", 20'(cap_fde[16]), 20'(fl ^ pl[2]));
    end else begin
      chk("R12 blank rise", cap_r[30], map(em, 10'h200, 10'h040, 8'h0, 8'h0, 8'h0, 1'b0));
      chk("R12 blank fall", cap_f[30], map(em, 10'h200, 10'h040, 8'h0, 8'h0, 8'h0, 1'b1));
      chk("R10 de on", 20'(cap_fde[16]), 20'(1'b1 ^ pl[2]));
      chk("R10 de off", 20'(cap_fde[15]), 20'(pl[2]));
    end
    chk("R9 hs idle", 20'(cap_hs[10]), 20'(pl[0]));
    chk("R9 hs pulse", 20'(cap_hs[11]), 20'(1'b1 ^ pl[0]));
    if (dovs) begin
      chk("R9 vs pulse", 20'(cap_vs[6]), 20'(1'b1 ^ pl[1]));
      chk("R9 vs idle", 20'(cap_vs[8]), 20'(pl[1]));
    end
    if (em <= 3) chk("R13 fall equals rise", cap_f[17], cap_r[17]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 oe after reset", pd_oe_o, 20'h0);
    chk("R1 data after reset", pd_rise_o, 20'h0);
    chk("R1 hs after reset", 20'(hs_o), 20'h0);
    for (int i = 0; i < NV; i++) begin
      run_line(VEC[i]);
      // second line of a frame after an odd-length line: first chroma must be Cb
      if (i == 2) chk("R8 line restart Cb", {10'h0, cap_r[16][9:0]}, {10'h0, cbv(0)});
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule